// File: doc/BRIEF.md
# Cascaded Biquad Lowpass Filter (16-bit fixed point)

This block is a fourth-order lowpass IIR filter built from two second-order direct-form sections in series. Every value inside it is a 16-bit two's-complement word. Every coefficient is a Q15 fraction. Each product is a fractional multiply: the 32-bit product is shifted right by 15 and truncated to 16 bits, so the result rounds toward minus infinity. After that, each product term gets a shift that is fixed when the block is built. The shifts are chosen so that partial sums may wrap while the final sum stays correct.

One sample is accepted when `in_valid` is high and the block is idle. A small sequencer then drives one multiplier and one accumulator through eleven multiply-accumulate steps, one step per clock. When the last step completes, the filtered sample appears on `out_sample` together with a single-cycle `out_valid` pulse. Each section keeps two delay words.

The equations below use these conventions:
- F(c,d) = (c·d) >>> 15, kept to 16 bits.
- `<<` wraps to 16 bits.
- `>>>` is an arithmetic right shift.
- Every add and subtract wraps modulo 2^16.

Top module: `biquad_cascade_lp`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `out_valid` is 0, `out_sample` is 0 and all four delay words are 0. A filter restarted by reset therefore answers a fresh input exactly as a filter that has never run.
- R2: An `in_valid` sampled high while the block is idle is accepted. `out_valid` rises on the 11th rising edge after the accepting edge. A new sample may be accepted on the edge that follows the `out_valid` cycle.
- R3: `out_valid` is high for exactly one cycle per accepted sample.
- R4: `in_valid` pulses that arrive while a sample is being processed are ignored. They do not change the result in progress and they produce no extra output.
- R5: `out_sample` holds its value between `out_valid` pulses.
- R6: Input scaling and section 1 compute the following, with gain g=24694, b=(24097, 9047) and a=(16384, 8486, 16384):
  - s = F(g,x)<<1
  - t1 = (s>>>3) + (F(b0,D0)<<1) − (F(b1,D1)<<1)
  - y1 = (F(a0,t1)<<1) − (F(a1,D0)<<1) + (F(a2,D1)<<1)
- R7: Section 2 computes the following, with b=(28546, 13450) and a=(16384, 26757, 16384):
  - t2 = (y1>>>4) + (F(b0,D0)<<1) − (F(b1,D1)<<1)
  - y = (F(a0,t2)<<3) − (F(a1,D0)<<3) + (F(a2,D1)<<3)
- R8: Products are truncated, never rounded. Every partial sum wraps modulo 2^16 with no saturation, so `out_sample` is bit-exact with the wrapping equations even for full-scale inputs.
- R9: After a section's output is formed, its delays shift: D1 takes the old D0, then D0 takes that sample's t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new output |
| out_sample | output | 16 | Filtered sample, two's complement |

## Verification
The assertions check the handshake on every cycle:
- `out_valid` never lasts two cycles.
- An idle strobe is always taken.
- `out_sample` changes only in a pulse cycle.
- The delay words never move while the block is idle.

Only the bench's scenarios can show the rest: the bit-exact arithmetic (truncation, wrap-around and the per-term shifts), the exact latency, and the effect of reset on the delay state. The bench compares every output against an integer model of the equations. It uses directed full-scale values, a long pseudo-random stream, strobes injected during processing, and a reset in the middle of a run.

// File: rtl/biquad_cascade_lp.sv
module biquad_cascade_lp #(
  parameter int WL = 16,
  parameter int G_IN = 24694,
  parameter int S1_B0 = 24097, parameter int S1_B1 = 9047,
  parameter int S1_A0 = 16384, parameter int S1_A1 = 8486, parameter int S1_A2 = 16384,
  parameter int S2_B0 = 28546, parameter int S2_B1 = 13450,
  parameter int S2_A0 = 16384, parameter int S2_A1 = 26757, parameter int S2_A2 = 16384,
  parameter int IN_SH = 1,
  parameter int S1_IN_RSH = 3,
  parameter int S1_SH = 1,
  parameter int S2_IN_RSH = 4,
  parameter int S2_T_SH = 1,
  parameter int S2_Y_SH = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [WL-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [WL-1:0] out_sample
);
  localparam logic [3:0] LAST = 4'd10;
  localparam logic [3:0] T1_STEP = 4'd2;
  localparam logic [3:0] S1_DONE = 4'd5;
  localparam logic [3:0] T2_STEP = 4'd7;

  logic                 busy;
  logic [3:0]           step;
  logic signed [WL-1:0] x_q, acc, tq;
  logic signed [WL-1:0] s1d0, s1d1, s2d0, s2d1;

  logic signed [WL-1:0]   c_sel, d_sel, base_v, term, acc_next;
  logic [1:0]             bsel;
  logic                   neg;
  logic [2:0]             lsh;
  logic signed [2*WL-1:0] prod;
  logic signed [WL-1:0]   fq;

  always_comb begin
    c_sel = '0; d_sel = '0; bsel = 2'd1; neg = 1'b0; lsh = 3'(S1_SH);
    case (step)
      4'd0:  begin c_sel = WL'(G_IN);  d_sel = x_q;  bsel = 2'd0; lsh = 3'(IN_SH); end
      4'd1:  begin c_sel = WL'(S1_B0); d_sel = s1d0; bsel = 2'd2; end
      4'd2:  begin c_sel = WL'(S1_B1); d_sel = s1d1; neg = 1'b1; end
      4'd3:  begin c_sel = WL'(S1_A0); d_sel = tq;   bsel = 2'd0; end
      4'd4:  begin c_sel = WL'(S1_A1); d_sel = s1d0; neg = 1'b1; end
      4'd5:  begin c_sel = WL'(S1_A2); d_sel = s1d1; end
      4'd6:  begin c_sel = WL'(S2_B0); d_sel = s2d0; bsel = 2'd3; lsh = 3'(S2_T_SH); end
      4'd7:  begin c_sel = WL'(S2_B1); d_sel = s2d1; neg = 1'b1; lsh = 3'(S2_T_SH); end
      4'd8:  begin c_sel = WL'(S2_A0); d_sel = tq;   bsel = 2'd0; lsh = 3'(S2_Y_SH); end
      4'd9:  begin c_sel = WL'(S2_A1); d_sel = s2d0; neg = 1'b1; lsh = 3'(S2_Y_SH); end
      4'd10: begin c_sel = WL'(S2_A2); d_sel = s2d1; lsh = 3'(S2_Y_SH); end
      default: ;
    endcase
  end

  assign prod = c_sel * d_sel;
  assign fq   = prod[2*WL-2:WL-1];
  assign term = fq <<< lsh;

  always_comb begin
    case (bsel)
      2'd0:    base_v = '0;
      2'd2:    base_v = acc >>> S1_IN_RSH;
      2'd3:    base_v = acc >>> S2_IN_RSH;
      default: base_v = acc;
    endcase
  end

  assign acc_next = neg ? base_v - term : base_v + term;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; step <= '0; x_q <= '0; acc <= '0; tq <= '0;
      s1d0 <= '0; s1d1 <= '0; s2d0 <= '0; s2d1 <= '0;
      out_valid <= 1'b0; out_sample <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy <= 1'b1;
          step <= '0;
          x_q  <= in_sample;
        end
      end else begin
        acc  <= acc_next;
        step <= step + 4'd1;
        if (step == T1_STEP || step == T2_STEP) tq <= acc_next;
        if (step == S1_DONE) begin
          s1d1 <= s1d0;
          s1d0 <= tq;
        end
        if (step == LAST) begin
          s2d1 <= s2d0;
          s2d0 <= tq;
          out_sample <= acc_next;
          out_valid  <= 1'b1;
          busy       <= 1'b0;
        end
      end
    end
  end

  // R3
  one_cycle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2
  accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && in_valid) |=> busy);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_sample) |-> out_valid);

  // R9
  delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(s1d0) && $stable(s1d1) && $stable(s2d0) && $stable(s2d1)));

  // R4
  ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && step != LAST) |=> ($stable(x_q) && busy));
endmodule

// File: tb/biquad_cascade_lp_tb_top.sv
`timescale 1ns/1ps
module biquad_cascade_lp_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic out_valid;
  logic signed [15:0] out_sample;

  int n_chk = 0;
  int n_bad = 0;
  int m1a = 0, m1b = 0, m2a = 0, m2b = 0;
  logic [15:0] lfsr = 16'hACE1;

  localparam logic signed [15:0] STIM [10] = '{
    16'sh7FFF, -16'sh8000, 16'sh0000, 16'sh0001, -16'sh0001,
    16'sh4000, -16'sh4000, 16'sh4E20, 16'sh7FFF, 16'sh7FFF};

  always #10 clk = ~clk;

  biquad_cascade_lp dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample));

  function automatic int w16(input int v);
    return int'(shortint'(v));
  endfunction

  function automatic int fm(input int c, input int d);
    return w16((c * d) >>> 15);
  endfunction

  function automatic int shl(input int v, input int k);
    return w16(v << k);
  endfunction

  function automatic int model(input int x);
    int s, t1, y1, t2, y;
    s  = shl(fm(24694, x), 1);
    t1 = w16((s >>> 3) + shl(fm(24097, m1a), 1) - shl(fm(9047, m1b), 1));
    y1 = w16(shl(fm(16384, t1), 1) - shl(fm(8486, m1a), 1) + shl(fm(16384, m1b), 1));
    m1b = m1a; m1a = t1;
    t2 = w16((y1 >>> 4) + shl(fm(28546, m2a), 1) - shl(fm(13450, m2b), 1));
    y  = w16(shl(fm(16384, t2), 3) - shl(fm(26757, m2a), 3) + shl(fm(16384, m2b), 3));
    m2b = m2a; m2a = t2;
    return y;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic signed [15:0] v, input bit inject);
    int exp, n;
    logic signed [15:0] held;
    exp = model(int'(v));
    @(negedge clk);
    in_valid = 1'b1; in_sample = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 40) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (inject && (n == 3 || n == 7)) begin
        in_valid = 1'b1; in_sample = 16'sh5A5A;
      end else in_valid = 1'b0;
    end
    in_valid = 1'b0;
    check(n == 11, "R2 latency", n, 11);
    check(int'(out_sample) == exp, "R6 R7 R8 R9 output", int'(out_sample), exp);
    held = out_sample;
    @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R3 pulse width", int'(out_valid), 0);
    check(out_sample == held, "R5 hold", int'(out_sample), int'(held));
    if (inject) begin
      n = 0;
      for (int i = 0; i < 15; i++) begin
        @(posedge clk);
        @(negedge clk);
        if (out_valid) n++;
      end
      check(n == 0, "R4 no extra output", n, 0);
      check(out_sample == held, "R5 hold idle", int'(out_sample), int'(held));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!out_valid && out_sample == 0, "R1 reset outputs", int'(out_sample), 0);
    rst = 1'b0;
    m1a = 0; m1b = 0; m2a = 0; m2b = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    foreach (STIM[i]) run_one(STIM[i], 1'b0);
    // R4: strobes while busy
    run_one(16'sh3000, 1'b1);
    run_one(-16'sh7000, 1'b1);
    // R8: sustained full-scale drive to force wrapping
    for (int i = 0; i < 40; i++) run_one((i % 2) ? -16'sh8000 : 16'sh7FFF, 1'b0);
    // R1: mid-run reset clears delays, impulse response restarts
    do_reset();
    for (int i = 0; i < 6; i++) run_one(i == 0 ? 16'sh4000 : 16'sh0000, 1'b0);
    for (int i = 0; i < 1000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_one(lfsr, (i % 97) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule